// File: doc/BRIEF.md
# Pointer-Window Host Register Interface

This block is the host-facing register file of a byte-wide serial bus controller. A microcontroller reaches it over an 8-bit parallel port with an active-low select, separate active-low read and write strobes and a 2-bit address. The port is not tied to the system clock. All of its lines pass through a two-stage synchroniser, and a small bus-access state machine in the system clock domain turns strobe overlaps into single-cycle write-commit and read-done events.

Only four slots are decoded directly: status, data, window and control. A write to slot 00 loads a 3-bit pointer. The pointer chooses one of seven configuration registers, and that register is then read or written through slot 10. The serial engine sits behind the registers and is represented here by a status input, a received-byte load input and the configuration outputs. A keyed two-write sequence to the write-only reset register returns every register to its reset value.

The bus-access state machine has three states. IDLE moves to WRITE while select and write are both low; otherwise IDLE moves to READ while select and read are both low. WRITE returns to IDLE when the overlap ends and commits the write. READ returns to IDLE when its overlap ends and signals read-done. The key state machine has two states. IDLE moves to ARMED on a write of A5h to the reset register. ARMED fires the reset and returns to IDLE on a write of 5Ah to that register. ARMED stays ARMED on another A5h to it, and returns to IDLE on any other write.

Top module: `ptr_window_regs`

## Requirements
- R1: After reset, ctrl_o=00h, tx_byte_o=00h, data_valid_o=0, the byte count register=00h, peer_addr_o=clk_lo_o=clk_hi_o=00h, timeout_o=FFh, mode_o=00h, soft_rst_o=0 and host_rdata_oe=0.
- R2: A write takes effect only if host_cs_n and host_wr_n are low at the same time, and it commits when the first of the two rises. A write strobe with select held high has no effect. A read strobe with select held high does not drive host_rdata_oe.
- R3: Slot 00 written stores host_wdata[2:0] as the indirect pointer. Slot 00 read returns eng_status_i.
- R4: Slot 01 written loads the shared data byte, which appears on tx_byte_o. Slot 01 read returns that byte.
- R5: Slot 11 is the read/write control byte and appears on ctrl_o.
- R6: Slot 10 reads and writes the indirect register picked by the pointer. Offsets: 0 byte count, 1 peer address, 2 clock-low, 3 clock-high, 4 timeout, 5 reset key, 6 mode. The pointer persists between accesses. A read does not change any configuration register.
- R7: In the byte count register, bit 7 drives cnt_last_o and bits 6:0 drive cnt_len_o.
- R8: A window read at pointer 5 (write-only) or pointer 7 (unused) returns FFh. A window write at pointer 7 changes nothing.
- R9: A rx_load_i pulse loads rx_byte_i into the data byte and sets data_valid_o. The end of a slot-01 read clears data_valid_o. If both fall in the same cycle, data_valid_o stays 1 and the new byte is held. A host write to slot 01 in the same cycle as rx_load_i is dropped.
- R10: Two consecutive writes of A5h and then 5Ah to indirect offset 5 produce a one-cycle soft_rst_o pulse. Every register then returns to its R1 value, and the pointer returns to 0. Any other write between the two keys aborts the sequence. A repeated A5h keeps the sequence armed.
- R11: A committed write is visible on the outputs after the third rising clock edge that follows the end of the strobe overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Slot address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, zero when not reading |
| host_rdata_oe | output | 1 | High while a read is in progress |
| eng_status_i | input | 8 | Engine status byte |
| rx_byte_i | input | 8 | Byte received by the engine |
| rx_load_i | input | 1 | Pulse: load rx_byte_i |
| data_valid_o | output | 1 | Unread received byte present |
| tx_byte_o | output | 8 | Shared data byte |
| ctrl_o | output | 8 | Control byte |
| cnt_last_o | output | 1 | Last-byte flag of byte count |
| cnt_len_o | output | 7 | Byte count value |
| peer_addr_o | output | 8 | Peer address register |
| clk_lo_o | output | 8 | Clock-low period register |
| clk_hi_o | output | 8 | Clock-high period register |
| timeout_o | output | 8 | Timeout register |
| mode_o | output | 8 | Mode register |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The clearing of the data-valid flag at the end of a slot-01 read and an engine load of a fresh byte can land on the same clock edge. The bench provokes this by pulsing rx_load_i in exactly the cycle where the synchronised read-done occurs, which is two falling edges after the strobe is released. It expects data_valid_o to stay high with the new byte on tx_byte_o. A second run pulses the load one cycle earlier and expects the flag to end low while the new byte is kept, which confirms that the load takes priority only when the two events coincide.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [1:0] {BA_IDLE, BA_WRITE, BA_READ} bus_state_e;
    typedef enum logic {UK_IDLE, UK_ARMED} key_state_e;

    localparam logic [1:0] SLOT_PTR_STAT = 2'b00;
    localparam logic [1:0] SLOT_DATA     = 2'b01;
    localparam logic [1:0] SLOT_WIN      = 2'b10;
    localparam logic [1:0] SLOT_CTRL     = 2'b11;

    localparam int OFS_COUNT = 0;
    localparam int OFS_PEER  = 1;
    localparam int OFS_CLKLO = 2;
    localparam int OFS_CLKHI = 3;
    localparam int OFS_TMO   = 4;
    localparam int OFS_KEY   = 5;
    localparam int OFS_MODE  = 6;

    localparam logic [7:0] KEY_FIRST  = 8'hA5;
    localparam logic [7:0] KEY_SECOND = 8'h5A;
    localparam logic [7:0] NO_READ    = 8'hFF;

    function automatic logic [7:0] ind_reset(input int idx);
        return (idx == OFS_TMO) ? 8'hFF : 8'h00;
    endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W = 13,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pipe[s] <= RST_VAL;
            else if (s == 0)
                pipe[s] <= d;
            else
                pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pwr_access.sv
module pwr_access
    import pwr_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_commit,
    output logic          rd_done,
    output logic          rd_busy,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_data
);
    bus_state_e st, st_nx;
    logic wr_act, rd_act;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BA_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            BA_IDLE:  st_nx = wr_act ? BA_WRITE : (rd_act ? BA_READ : BA_IDLE);
            BA_WRITE: st_nx = wr_act ? BA_WRITE : BA_IDLE;
            BA_READ:  st_nx = rd_act ? BA_READ : BA_IDLE;
            default:  st_nx = BA_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = (st == BA_WRITE) && !wr_act;
        rd_done   = (st == BA_READ) && !rd_act;
        rd_busy   = (st == BA_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr <= '0;
            acc_data <= '0;
        end else begin
            if (st_nx != BA_IDLE) acc_addr <= addr;
            if (st_nx == BA_WRITE) acc_data <= din;
        end
    end

    assert_commit_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!cs_n && !wr_n));
endmodule

// File: rtl/pwr_keylock.sv
module pwr_keylock
    import pwr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_any,
    input  logic          key_wr,
    input  logic [DW-1:0] wdata,
    output logic          fire
);
    key_state_e ks, ks_nx;
    logic fire_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks   <= UK_IDLE;
            fire <= 1'b0;
        end else begin
            ks   <= ks_nx;
            fire <= fire_nx;
        end
    end

    always_comb begin
        ks_nx   = ks;
        fire_nx = 1'b0;
        if (wr_any) begin
            unique case (ks)
                UK_IDLE: ks_nx = (key_wr && wdata == KEY_FIRST) ? UK_ARMED : UK_IDLE;
                UK_ARMED: begin
                    if (key_wr && wdata == KEY_SECOND) begin
                        ks_nx   = UK_IDLE;
                        fire_nx = 1'b1;
                    end else if (key_wr && wdata == KEY_FIRST) begin
                        ks_nx = UK_ARMED;
                    end else begin
                        ks_nx = UK_IDLE;
                    end
                end
                default: ks_nx = UK_IDLE;
            endcase
        end
    end

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    assert_fire_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(ks == UK_ARMED));
endmodule

// File: rtl/pwr_indirect.sv
module pwr_indirect
    import pwr_pkg::*;
#(
    parameter int DW = 8,
    parameter int IND_N = 7,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          we,
    input  logic [PW-1:0] ptr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] regs_o [IND_N]
);
    for (genvar i = 0; i < IND_N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_o[i] <= DW'(ind_reset(i));
            else if (srst)
                regs_o[i] <= DW'(ind_reset(i));
            else if (we && ptr == PW'(i))
                regs_o[i] <= wdata;
        end
    end

    always_comb begin
        rdata = DW'(NO_READ);
        for (int i = 0; i < IND_N; i++) begin
            if (i != OFS_KEY && ptr == PW'(i)) rdata = regs_o[i];
        end
    end

    assert_srst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (regs_o[OFS_TMO] == DW'(8'hFF) && regs_o[OFS_MODE] == '0 && regs_o[OFS_COUNT] == '0));
endmodule

// File: rtl/ptr_window_regs.sv
module ptr_window_regs
    import pwr_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2,
    parameter int IND_N = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_oe,
    input  logic [DW-1:0] eng_status_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          rx_load_i,
    output logic          data_valid_o,
    output logic [DW-1:0] tx_byte_o,
    output logic [DW-1:0] ctrl_o,
    output logic          cnt_last_o,
    output logic [DW-2:0] cnt_len_o,
    output logic [DW-1:0] peer_addr_o,
    output logic [DW-1:0] clk_lo_o,
    output logic [DW-1:0] clk_hi_o,
    output logic [DW-1:0] timeout_o,
    output logic [DW-1:0] mode_o,
    output logic          soft_rst_o
);
    localparam int SW = 3 + AW + DW;
    localparam int PW = $clog2(IND_N + 1);
    localparam logic [SW-1:0] SYNC_RST = {3'b111, {(AW + DW){1'b0}}};

    logic [SW-1:0] sync_q;
    logic          s_cs_n, s_rd_n, s_wr_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;

    pwr_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({host_cs_n, host_rd_n, host_wr_n, host_addr, host_wdata}),
        .q(sync_q)
    );
    assign {s_cs_n, s_rd_n, s_wr_n, s_addr, s_din} = sync_q;

    logic          wr_commit, rd_done, rd_busy;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;

    pwr_access #(.AW(AW), .DW(DW)) u_access (
        .clk(clk), .rst_n(rst_n),
        .cs_n(s_cs_n), .rd_n(s_rd_n), .wr_n(s_wr_n),
        .addr(s_addr), .din(s_din),
        .wr_commit(wr_commit), .rd_done(rd_done), .rd_busy(rd_busy),
        .acc_addr(acc_addr), .acc_data(acc_data)
    );

    logic [PW-1:0] ptr_q;
    logic [DW-1:0] ctrl_q, data_q;
    logic          valid_q;
    logic          srst;
    logic          wr_ptr, wr_data, wr_win, wr_ctrl, rd_data_end, key_wr;

    assign srst        = soft_rst_o;
    assign wr_ptr      = wr_commit && acc_addr == SLOT_PTR_STAT;
    assign wr_data     = wr_commit && acc_addr == SLOT_DATA;
    assign wr_win      = wr_commit && acc_addr == SLOT_WIN;
    assign wr_ctrl     = wr_commit && acc_addr == SLOT_CTRL;
    assign rd_data_end = rd_done && acc_addr == SLOT_DATA;
    assign key_wr      = wr_win && ptr_q == PW'(OFS_KEY);

    pwr_keylock #(.DW(DW)) u_key (
        .clk(clk), .rst_n(rst_n),
        .wr_any(wr_commit), .key_wr(key_wr), .wdata(acc_data),
        .fire(soft_rst_o)
    );

    logic [DW-1:0] ind_rdata;
    logic [DW-1:0] ind_q [IND_N];

    pwr_indirect #(.DW(DW), .IND_N(IND_N), .PW(PW)) u_ind (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .we(wr_win), .ptr(ptr_q), .wdata(acc_data),
        .rdata(ind_rdata), .regs_o(ind_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            ctrl_q <= '0;
        end else if (srst) begin
            ptr_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ptr)  ptr_q  <= acc_data[PW-1:0];
            if (wr_ctrl) ctrl_q <= acc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (srst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (rx_load_i) begin
            data_q  <= rx_byte_i;
            valid_q <= 1'b1;
        end else begin
            if (wr_data)     data_q  <= acc_data;
            if (rd_data_end) valid_q <= 1'b0;
        end
    end

    logic [DW-1:0] rd_mux;
    always_comb begin
        unique case (acc_addr)
            SLOT_PTR_STAT: rd_mux = eng_status_i;
            SLOT_DATA:     rd_mux = data_q;
            SLOT_WIN:      rd_mux = ind_rdata;
            default:       rd_mux = ctrl_q;
        endcase
    end

    assign host_rdata    = rd_busy ? rd_mux : '0;
    assign host_rdata_oe = rd_busy;
    assign data_valid_o  = valid_q;
    assign tx_byte_o     = data_q;
    assign ctrl_o        = ctrl_q;
    assign cnt_last_o    = ind_q[OFS_COUNT][DW-1];
    assign cnt_len_o     = ind_q[OFS_COUNT][DW-2:0];
    assign peer_addr_o   = ind_q[OFS_PEER];
    assign clk_lo_o      = ind_q[OFS_CLKLO];
    assign clk_hi_o      = ind_q[OFS_CLKHI];
    assign timeout_o     = ind_q[OFS_TMO];
    assign mode_o        = ind_q[OFS_MODE];

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid_o) |-> $past(rx_load_i));
    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid_o) |-> ($past(rd_done && acc_addr == SLOT_DATA) || $past(soft_rst_o)));
    assert_read_no_side_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> ($stable(ctrl_o) && $stable(timeout_o) && $stable(mode_o)
                     && $stable(peer_addr_o) && $stable(cnt_len_o)));
endmodule

// File: tb/tb_ptr_window_regs.sv
module tb_ptr_window_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_oe;
    logic [7:0] status = 8'h00;
    logic [7:0] rx_byte = 8'h00;
    logic rx_load = 1'b0;
    logic data_valid, cnt_last, soft_rst;
    logic [7:0] tx_byte, ctrl, peer, clo, chi, tmo, mode;
    logic [6:0] cnt_len;

    always #2 clk = ~clk;

    ptr_window_regs dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata), .host_rdata_oe(rdata_oe),
        .eng_status_i(status), .rx_byte_i(rx_byte), .rx_load_i(rx_load),
        .data_valid_o(data_valid), .tx_byte_o(tx_byte), .ctrl_o(ctrl),
        .cnt_last_o(cnt_last), .cnt_len_o(cnt_len),
        .peer_addr_o(peer), .clk_lo_o(clo), .clk_hi_o(chi),
        .timeout_o(tmo), .mode_o(mode), .soft_rst_o(soft_rst)
    );

    int n_chk = 0, n_err = 0, n_pulse = 0;
    logic [7:0] m_ctrl, m_data;
    logic m_valid;
    logic [7:0] m_ind [7];
    int m_ptr;

    always @(posedge clk) if (rst_n && soft_rst) n_pulse++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 8'h00; m_data = 8'h00; m_valid = 1'b0; m_ptr = 0;
        for (int i = 0; i < 7; i++) m_ind[i] = (i == 4) ? 8'hFF : 8'h00;
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'b00: return status;
            2'b01: return m_data;
            2'b10: return (m_ptr < 7 && m_ptr != 5) ? m_ind[m_ptr] : 8'hFF;
            default: return m_ctrl;
        endcase
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit wr_first);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        if (wr_first) wr_n = 1'b1; else cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_write(a, d, bit'($urandom % 2));
        case (a)
            2'b00: m_ptr = int'(d[2:0]);
            2'b01: m_data = d;
            2'b10: if (m_ptr < 7) m_ind[m_ptr] = d;
            default: m_ctrl = d;
        endcase
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata; en = rdata_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        if (a == 2'b01) m_valid = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_load = 1'b1;
        @(negedge clk);
        rx_load = 1'b0;
        m_data = b; m_valid = 1'b1;
    endtask

    task automatic check_outputs(input string req);
        chk(req, ctrl, m_ctrl);
        chk(req, tx_byte, m_data);
        chk(req, {7'd0, data_valid}, {7'd0, m_valid});
        chk(req, {cnt_last, cnt_len}, m_ind[0]);
        chk(req, peer, m_ind[1]);
        chk(req, clo, m_ind[2]);
        chk(req, chi, m_ind[3]);
        chk(req, tmo, m_ind[4]);
        chk(req, mode, m_ind[6]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic oe;
        int seed;
        seed = $urandom(32'd7341);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_outputs("R1");
        chk("R1", {6'd0, soft_rst, rdata_oe}, 8'h00);
        wr(2'b00, 8'h04);
        bus_read(2'b10, rv, oe);
        chk("R1", rv, 8'hFF);

        // R2 strobes without select
        @(negedge clk);
        addr = 2'b11; wdata = 8'h3C; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", ctrl, m_ctrl);
        addr = 2'b11; rd_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2", {7'd0, rdata_oe}, 8'h00);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 latency of a committed write
        @(negedge clk);
        addr = 2'b11; wdata = 8'hC3; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", ctrl, m_ctrl);
        @(negedge clk);
        chk("R11", ctrl, 8'hC3);
        m_ctrl = 8'hC3;
        repeat (4) @(negedge clk);

        // R3 status read
        status = 8'h96;
        bus_read(2'b00, rv, oe);
        chk("R3", rv, 8'h96);
        chk("R3", {7'd0, oe}, 8'h01);

        // R4 data byte, R5 control
        wr(2'b01, 8'h6E);
        chk("R4", tx_byte, 8'h6E);
        bus_read(2'b01, rv, oe);
        chk("R4", rv, 8'h6E);
        wr(2'b11, 8'h81);
        bus_read(2'b11, rv, oe);
        chk("R5", rv, 8'h81);
        chk("R5", ctrl, 8'h81);

        // R7 byte count fields, R6 pointer persistence
        wr(2'b00, 8'h00);
        wr(2'b10, 8'h85);
        chk("R7", {7'd0, cnt_last}, 8'h01);
        chk("R7", {1'b0, cnt_len}, 8'h05);
        bus_read(2'b10, rv, oe);
        chk("R6", rv, 8'h85);
        wr(2'b00, 8'h06);
        wr(2'b10, 8'h02);
        bus_read(2'b10, rv, oe);
        chk("R6", rv, 8'h02);
        chk("R6", mode, 8'h02);

        // R8 write-only and unused pointer
        wr(2'b00, 8'h05);
        wr(2'b10, 8'h33);
        bus_read(2'b10, rv, oe);
        chk("R8", rv, 8'hFF);
        wr(2'b00, 8'h07);
        wr(2'b10, 8'h44);
        bus_read(2'b10, rv, oe);
        chk("R8", rv, 8'hFF);
        check_outputs("R8");

        // R9 load sets, read clears
        rx_push(8'h11);
        chk("R9", {7'd0, data_valid}, 8'h01);
        chk("R9", tx_byte, 8'h11);
        // R9 collision: load in the read-done cycle
        @(negedge clk);
        addr = 2'b01; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", rdata, 8'h11);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rx_byte = 8'h99; rx_load = 1'b1;
        @(negedge clk);
        rx_load = 1'b0;
        chk("R9", {7'd0, data_valid}, 8'h01);
        chk("R9", tx_byte, 8'h99);
        m_data = 8'h99; m_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R9 load one cycle before read-done
        @(negedge clk);
        addr = 2'b01; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        rx_byte = 8'h44; rx_load = 1'b1;
        @(negedge clk);
        rx_load = 1'b0;
        @(negedge clk);
        chk("R9", {7'd0, data_valid}, 8'h00);
        chk("R9", tx_byte, 8'h44);
        m_data = 8'h44; m_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R10 aborted sequence
        wr(2'b11, 8'h77);
        wr(2'b00, 8'h05);
        wr(2'b10, 8'hA5);
        wr(2'b11, 8'h78);
        wr(2'b10, 8'h5A);
        chk("R10", n_pulse[7:0], 8'h00);
        chk("R10", ctrl, 8'h78);
        // R10 re-armed sequence fires
        wr(2'b10, 8'hA5);
        wr(2'b10, 8'hA5);
        wr(2'b10, 8'h5A);
        chk("R10", n_pulse[7:0], 8'h01);
        model_reset();
        check_outputs("R10");
        bus_read(2'b10, rv, oe);
        chk("R10", rv, 8'h00);

        // random traffic, R3 R4 R5 R6 R8 R9
        for (int it = 0; it < 80; it++) begin
            int op;
            logic [1:0] ra;
            logic [7:0] d;
            op = int'($urandom % 6);
            d = 8'($urandom);
            status = 8'($urandom);
            case (op)
                0: wr(2'b00, d);
                1: begin
                    if (m_ptr == 5 && (d == 8'hA5 || d == 8'h5A)) d = 8'h00;
                    wr(2'b10, d);
                end
                2: wr(2'b11, d);
                3: if (!rx_load) wr(2'b01, d);
                4: begin
                    ra = 2'($urandom);
                    bus_read(ra, rv, oe);
                    chk("R6", rv, (ra == 2'b00) ? status : exp_read(ra));
                end
                default: rx_push(d);
            endcase
            check_outputs("R9");
        end
        chk("R10", n_pulse[7:0], 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule